// File: doc/BRIEF.md
# Processor Trap and Interrupt Controller

This block owns a processor's status word and its exception state, and decides in which cycle the program counter must be redirected to the trap handler. The core supplies interrupt lines, a synchronous exception request with a cause code, the PC of the instruction at the fetch boundary and the faulting address. The block answers in the same cycle with a redirect strobe and the handler address. It also records the cause, exception PC and bad address for the handler to read.

A free-running retire counter is compared against a software-written compare value and raises a timer interrupt on one of the interrupt lines. Status writes from software are cleaned according to the build's 64-bit and floating-point support. The block also reports the register-width mode in force and a sticky error flag for a trap that could not be taken.

Top module: `trap_ctrl`

## Requirements
- R1: After reset the status word is 0x28 (supervisor set, 64-bit supervisor enabled when 64-bit support is built in), error is low, and cause, exception PC, bad address, handler address, retire count, compare value and timer pending are all zero.
- R2: Status word bit positions: bit 0 trap enable, bit 1 FP enable, bit 2 previous supervisor, bit 3 supervisor, bit 4 user 64-bit enable, bit 5 supervisor 64-bit enable, bits 8 and up one interrupt mask bit per line. An interrupt is taken only when `fetch_i` is high, trap enable is set, and some pending line has its mask bit set.
- R3: With several unmasked lines pending, the lowest-numbered one is taken, and the recorded cause is 16 plus its index.
- R4: A synchronous exception takes priority over an interrupt in the same cycle, and the recorded cause is `exc_cause_i`.
- R5: On trap entry trap enable is cleared, supervisor is set, and the previous-supervisor bit takes the old supervisor bit. A status write in the same cycle is dropped.
- R6: A trap asserts `redirect_o` in the same cycle, with `redirect_pc_o` equal to the handler address register. On the next edge the exception PC takes `pc_i` and the bad address takes `badaddr_i`.
- R7: A trap request while trap enable is clear sets `err_o`, which stays set until reset. It gives no redirect and changes no exception register. While `err_o` is set no trap is taken.
- R8: Each cycle with `retire_i` high increments the retire count. If the count before the increment equals the compare value, the timer line (index `TIMER_IRQ`, default 7, ORed with `irq_i`) becomes pending.
- R9: Writing the compare value clears the timer pending bit, and this wins over a match in the same cycle.
- R10: A status write keeps only the defined bits. The 64-bit enable bits are cleared when 64-bit support is absent, and FP enable is cleared when FP support is absent. With both supported, writing all ones gives 0xFF3F.
- R11: `wide_o` is the supervisor 64-bit enable when supervisor is set, else the user 64-bit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | NIRQ | Level interrupt lines |
| fetch_i | input | 1 | Instruction boundary: interrupts are sampled |
| retire_i | input | 1 | An instruction retires this cycle |
| exc_valid_i | input | 1 | Synchronous exception request |
| exc_cause_i | input | CW | Cause code of the exception |
| pc_i | input | XLEN | PC of the current instruction |
| badaddr_i | input | XLEN | Faulting address |
| sr_we_i | input | 1 | Status write strobe |
| sr_wdata_i | input | 32 | Status write value |
| evec_we_i | input | 1 | Handler address write strobe |
| evec_wdata_i | input | XLEN | Handler address value |
| cmp_we_i | input | 1 | Compare write strobe |
| cmp_wdata_i | input | CNT_W | Compare value |
| redirect_o | output | 1 | Take a trap this cycle |
| redirect_pc_o | output | XLEN | Handler address |
| cause_o | output | CW | Recorded cause |
| epc_o | output | XLEN | Recorded exception PC |
| badaddr_o | output | XLEN | Recorded bad address |
| sr_o | output | 32 | Status word |
| wide_o | output | 1 | 64-bit register mode in force |
| err_o | output | 1 | Sticky error mode |

## Verification
A wrong trap-enable or mask state shows in the very cycle of the next fetch boundary, as a redirect that should not happen or a missing one. A wrong supervisor or previous-supervisor bit appears on `sr_o` and `wide_o` one edge after the trap. A wrong retire count or compare value shows only later, when the timer line is taken with cause 23 too early or too late. For that reason the bench runs a reference model of the count and compares every output on every clock.

// File: rtl/trap_ctrl.sv
module trap_ctrl #(
  parameter int XLEN      = 64,
  parameter int NIRQ      = 8,
  parameter int TIMER_IRQ = 7,
  parameter int CNT_W     = 32,
  parameter bit HAS_64    = 1'b1,
  parameter bit HAS_FP    = 1'b1,
  localparam int CW       = $clog2(16 + NIRQ)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NIRQ-1:0]  irq_i,
  input  logic             fetch_i,
  input  logic             retire_i,
  input  logic             exc_valid_i,
  input  logic [CW-1:0]    exc_cause_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  badaddr_i,
  input  logic             sr_we_i,
  input  logic [31:0]      sr_wdata_i,
  input  logic             evec_we_i,
  input  logic [XLEN-1:0]  evec_wdata_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] cmp_wdata_i,
  output logic             redirect_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic [CW-1:0]    cause_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  badaddr_o,
  output logic [31:0]      sr_o,
  output logic             wide_o,
  output logic             err_o
);
  localparam int B_ET = 0, B_EF = 1, B_PS = 2, B_SV = 3, B_UX = 4, B_SX = 5, IM_LO = 8;
  localparam logic [31:0] IM_MASK = ((32'(1) << NIRQ) - 32'(1)) << IM_LO;
  localparam logic [31:0] SR_KEEP = IM_MASK | (32'(1) << B_ET) | (32'(1) << B_PS) | (32'(1) << B_SV)
                                  | (32'(HAS_FP) << B_EF)
                                  | (32'(HAS_64) << B_UX) | (32'(HAS_64) << B_SX);
  localparam logic [31:0] SR_RST  = (32'(1) << B_SV) | (32'(HAS_64) << B_SX);

  logic [31:0]      sr;
  logic [XLEN-1:0]  evec;
  logic [CNT_W-1:0] cnt, cmp;
  logic             tmr_pend;
  logic [NIRQ-1:0]  live;
  logic [CW-1:0]    irq_idx;
  logic             take;

  assign live = (irq_i | (NIRQ'(tmr_pend) << TIMER_IRQ)) & sr[IM_LO +: NIRQ];

  always_comb begin
    irq_idx = '0;
    for (int i = NIRQ - 1; i >= 0; i--)
      if (live[i]) irq_idx = CW'(i);
  end

  assign take          = !err_o && (exc_valid_i || (fetch_i && sr[B_ET] && |live));
  assign redirect_o    = take && sr[B_ET];
  assign redirect_pc_o = evec;
  assign sr_o          = sr;
  assign wide_o        = sr[B_SV] ? sr[B_SX] : sr[B_UX];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= SR_RST;
      evec      <= '0;
      epc_o     <= '0;
      badaddr_o <= '0;
      cause_o   <= '0;
      cnt       <= '0;
      cmp       <= '0;
      tmr_pend  <= 1'b0;
      err_o     <= 1'b0;
    end else begin
      if (take && !sr[B_ET]) err_o <= 1'b1;
      if (redirect_o) begin
        sr        <= (sr & ~((32'(1) << B_ET) | (32'(1) << B_PS)))
                   | (32'(1) << B_SV) | (32'(sr[B_SV]) << B_PS);
        cause_o   <= exc_valid_i ? exc_cause_i : CW'(16) + irq_idx;
        epc_o     <= pc_i;
        badaddr_o <= badaddr_i;
      end else if (sr_we_i) begin
        sr <= sr_wdata_i & SR_KEEP;
      end
      if (evec_we_i) evec <= evec_wdata_i;
      if (retire_i) cnt <= cnt + 1'b1;
      if (cmp_we_i) begin
        cmp      <= cmp_wdata_i;
        tmr_pend <= 1'b0;
      end else if (retire_i && cnt == cmp) begin
        tmr_pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/trap_ctrl_chk.sv
module trap_ctrl_chk #(
  parameter int XLEN   = 64,
  parameter int NIRQ   = 8,
  parameter bit HAS_64 = 1'b1,
  parameter bit HAS_FP = 1'b1,
  localparam int CW    = $clog2(16 + NIRQ)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            exc_valid_i,
  input logic [CW-1:0]   exc_cause_i,
  input logic [XLEN-1:0] pc_i,
  input logic            redirect_o,
  input logic [CW-1:0]   cause_o,
  input logic [XLEN-1:0] epc_o,
  input logic [31:0]     sr_o,
  input logic            err_o
);
  localparam logic [31:0] KEEP = ((((32'(1) << NIRQ) - 32'(1)) << 8) | 32'h0000_000D
                               | (32'(HAS_FP) << 1) | (32'(HAS_64) << 4) | (32'(HAS_64) << 5));

  p_redirect_needs_et_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> sr_o[0]);
  p_entry_clears_et_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !sr_o[0] && sr_o[3]);
  p_entry_saves_sv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> sr_o[2] == $past(sr_o[3]));
  p_entry_epc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> epc_o == $past(pc_i));
  p_irq_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && !exc_valid_i) |=> cause_o >= CW'(16));
  p_exc_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && exc_valid_i) |=> cause_o == $past(exc_cause_i));
  p_fault_sets_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_valid_i && !sr_o[0]) |=> err_o);
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  p_err_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !redirect_o);
  p_reserved_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_o & ~KEEP) == 32'h0);
endmodule

bind trap_ctrl trap_ctrl_chk #(.XLEN(XLEN), .NIRQ(NIRQ), .HAS_64(HAS_64), .HAS_FP(HAS_FP)) u_chk (.*);

// File: tb/test_trap_ctrl.sv
module test_trap_ctrl;
  localparam int XLEN = 64, NIRQ = 8, CW = 5, CNT_W = 32;

  logic clk = 0, rst_n = 0;
  logic [NIRQ-1:0] irq_i = 0;
  logic fetch_i = 0, retire_i = 0, exc_valid_i = 0, sr_we_i = 0, evec_we_i = 0, cmp_we_i = 0;
  logic [CW-1:0] exc_cause_i = 0;
  logic [XLEN-1:0] pc_i = 0, badaddr_i = 0, evec_wdata_i = 0;
  logic [31:0] sr_wdata_i = 0;
  logic [CNT_W-1:0] cmp_wdata_i = 0;
  logic redirect_o, wide_o, err_o;
  logic [XLEN-1:0] redirect_pc_o, epc_o, badaddr_o;
  logic [CW-1:0] cause_o;
  logic [31:0] sr_o;

  trap_ctrl i_trap_ctrl (.*);

  always #2 clk = ~clk;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_sr;
  logic [63:0] m_evec, m_epc, m_bad;
  int unsigned m_cnt, m_cmp;
  int m_cause;
  bit m_tp, m_err;

  task automatic chk(string req, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic bit m_take();
    bit any = 0;
    for (int i = 0; i < NIRQ; i++)
      if ((irq_i[i] || (i == 7 && m_tp)) && m_sr[8 + i]) any = 1;
    return !m_err && (exc_valid_i || (fetch_i && m_sr[0] && any));
  endfunction

  function automatic int m_low();
    for (int i = 0; i < NIRQ; i++)
      if ((irq_i[i] || (i == 7 && m_tp)) && m_sr[8 + i]) return i;
    return 0;
  endfunction

  task automatic m_reset();
    m_sr = 32'h28; m_evec = 0; m_epc = 0; m_bad = 0; m_cause = 0;
    m_cnt = 0; m_cmp = 0; m_tp = 0; m_err = 0;
  endtask

  task automatic idle();
    irq_i = 0; fetch_i = 0; retire_i = 0; exc_valid_i = 0; sr_we_i = 0;
    evec_we_i = 0; cmp_we_i = 0;
  endtask

  task automatic do_reset();
    idle();
    rst_n = 0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    m_reset();
  endtask

  task automatic cyc();
    bit t, red;
    #1;
    t = m_take();
    red = t && m_sr[0];
    chk("R2", "redirect", redirect_o, red);
    chk("R6", "redirect_pc", redirect_pc_o, m_evec);
    @(posedge clk);
    if (t && !m_sr[0]) m_err = 1;
    if (red) begin
      m_cause = exc_valid_i ? int'(exc_cause_i) : 16 + m_low();
      m_epc = pc_i; m_bad = badaddr_i;
      m_sr = (m_sr & ~32'h5) | 32'h8 | (m_sr[3] ? 32'h4 : 32'h0);
    end else if (sr_we_i) m_sr = sr_wdata_i & 32'hFF3F;
    if (evec_we_i) m_evec = evec_wdata_i;
    if (cmp_we_i) begin m_cmp = cmp_wdata_i; m_tp = 0; end
    else if (retire_i && m_cnt == m_cmp) m_tp = 1;
    if (retire_i) m_cnt++;
    @(negedge clk);
    chk("R5", "sr", sr_o, m_sr);
    chk("R3", "cause", cause_o, m_cause);
    chk("R6", "epc", epc_o, m_epc);
    chk("R6", "badaddr", badaddr_o, m_bad);
    chk("R11", "wide", wide_o, m_sr[3] ? m_sr[5] : m_sr[4]);
    chk("R7", "err", err_o, m_err);
    idle();
  endtask

  task automatic wsr(logic [31:0] v);
    sr_we_i = 1; sr_wdata_i = v; cyc();
  endtask

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1", "sr", sr_o, 32'h28);
    chk("R1", "err", err_o, 0);
    chk("R1", "epc", epc_o, 0);
    chk("R1", "cause", cause_o, 0);
    chk("R1", "wide", wide_o, 1);
    // R1/R8 count and compare both zero: first retire matches
    retire_i = 1; cyc();
    wsr(32'h0000_8009);
    fetch_i = 1; cyc();
    chk("R8", "timer cause", cause_o, 23);
    // R9 compare write clears timer pending
    cmp_we_i = 1; cmp_wdata_i = 3; retire_i = 1; cyc();
    wsr(32'h0000_8009);
    fetch_i = 1; #1; chk("R9", "no timer redirect", redirect_o, 0); cyc();
    // R8 count 2 -> retire at 2 no match, at 3 match
    retire_i = 1; cyc();
    fetch_i = 1; #1; chk("R8", "early timer", redirect_o, 0); cyc();
    retire_i = 1; cyc();
    fetch_i = 1; #1; chk("R8", "timer fires", redirect_o, 1); cyc();
    chk("R8", "timer cause", cause_o, 23);
    cmp_we_i = 1; cmp_wdata_i = 32'hFFFF_FFFF; cyc();
    // R10 sanitise
    wsr(32'hFFFF_FFFF);
    chk("R10", "sr all ones", sr_o, 32'h0000_FF3F);
    // R11 width selection
    wsr(32'h0000_0020); chk("R11", "user no UX", wide_o, 0);
    wsr(32'h0000_0010); chk("R11", "user UX", wide_o, 1);
    wsr(32'h0000_0018); chk("R11", "sup no SX", wide_o, 0);
    // R2 masking and fetch gating
    wsr(32'h0000_0009);
    irq_i = 8'h04; fetch_i = 1; #1; chk("R2", "masked", redirect_o, 0); cyc();
    wsr(32'h0000_0409);
    irq_i = 8'h04; #1; chk("R2", "no fetch", redirect_o, 0); cyc();
    wsr(32'h0000_0408);
    irq_i = 8'h04; fetch_i = 1; #1; chk("R2", "et clear", redirect_o, 0); cyc();
    chk("R2", "no err from irq", err_o, 0);
    wsr(32'h0000_0409);
    evec_we_i = 1; evec_wdata_i = 64'h1000; cyc();
    irq_i = 8'h04; fetch_i = 1; pc_i = 64'hABC; badaddr_i = 64'hDEAD;
    #1; chk("R6", "redirect pc", redirect_pc_o, 64'h1000); cyc();
    chk("R3", "cause 18", cause_o, 18);
    chk("R6", "epc", epc_o, 64'hABC);
    chk("R6", "badaddr", badaddr_o, 64'hDEAD);
    chk("R5", "et cleared", sr_o[0], 0);
    chk("R5", "ps from sv", sr_o[2], 1);
    // R3 lowest wins
    wsr(32'h0000_FF01);
    irq_i = 8'b0110_1000; fetch_i = 1; cyc();
    chk("R3", "lowest", cause_o, 19);
    chk("R5", "ps from user", sr_o[2], 0);
    chk("R5", "sv set", sr_o[3], 1);
    // R4 exception beats interrupt
    wsr(32'h0000_FF09);
    irq_i = 8'h01; fetch_i = 1; exc_valid_i = 1; exc_cause_i = 5; cyc();
    chk("R4", "exc cause", cause_o, 5);
    // R5 status write dropped on trap
    wsr(32'h0000_0009);
    exc_valid_i = 1; exc_cause_i = 2; sr_we_i = 1; sr_wdata_i = 32'h0000_0031; cyc();
    chk("R5", "write dropped", sr_o, 32'h0000_000C);
    // R7 fault
    pc_i = 64'h5555; exc_valid_i = 1; exc_cause_i = 3;
    #1; chk("R7", "no redirect", redirect_o, 0); cyc();
    chk("R7", "err set", err_o, 1);
    chk("R7", "epc kept", epc_o, 64'hABC);
    wsr(32'h0000_0009);
    exc_valid_i = 1; #1; chk("R7", "blocked", redirect_o, 0); cyc();
    chk("R7", "sticky", err_o, 1);
    // reference-model random run
    for (int blk = 0; blk < 20; blk++) begin
      do_reset();
      for (int n = 0; n < 300; n++) begin
        irq_i = NIRQ'($urandom);
        fetch_i = $urandom_range(0, 1);
        retire_i = $urandom_range(0, 1);
        exc_valid_i = ($urandom_range(0, 15) == 0);
        exc_cause_i = CW'($urandom_range(0, 15));
        pc_i = {$urandom, $urandom};
        badaddr_i = {$urandom, $urandom};
        sr_we_i = ($urandom_range(0, 3) == 0);
        sr_wdata_i = $urandom | 32'h1;
        evec_we_i = ($urandom_range(0, 7) == 0);
        evec_wdata_i = {$urandom, $urandom};
        cmp_we_i = ($urandom_range(0, 15) == 0);
        cmp_wdata_i = CNT_W'($urandom_range(0, 40));
        cyc();
      end
    end
    finish_up();
  end
endmodule